// File: doc/BRIEF.md
# Pixel Clock Source Selector and Prescaler

This block derives the display pixel clock from one of three incoming master clocks. A five-bit control field picks the master clock and an integer divide ratio from 1 to 8. The chosen clock is gated onto `pix_clk` through a glitch-free multiplexer. A down-counter running on `pix_clk` raises `pix_en` for one cycle in every N, and display logic in the `pix_clk` domain uses it as its pixel-rate enable. Source 2 is meant for a dedicated high-frequency input, so pixel rates up to about 120 MHz remain possible when the synthesised clock cannot reach them.

The control field is loaded from a write port. The port is clocked by `clk_src0` and uses a strobe with a data byte. When the source is changed, the old clock is gated off while it is low, and only then is the new clock enabled, also while it is low. When the divide ratio is changed, the new value waits for the end of the current pixel period.

Top module: `pixclk_sel_div`

## Requirements
- R1: Bits [1:0] of the control field pick the source: 0 selects `clk_src0`, 1 selects `clk_src1` and 2 selects `clk_src2`. Once the switch has settled, `pix_clk` follows the selected clock.
- R2: Source code 3 is reserved and behaves exactly like code 0.
- R3: Bits [4:2] hold N-1. `pix_en` is high for one `pix_clk` cycle out of every N, so successive `pix_en` cycles are N source periods apart.
- R4: With bits [4:2] = 0, `pix_en` stays high on every `pix_clk` cycle.
- R5: A new divide ratio is adopted only at a cycle where `pix_en` is high. No interval between `pix_en` pulses is shorter than the old or the new N times the source period.
- R6: During a source change, no high or low phase of `pix_clk` is shorter than the shorter half period of the old and new sources.
- R7: At most one source is gated onto `pix_clk` at any time.
- R8: While `rst_n` is low, `pix_clk` is held low. Reset selects source 0 with divide by 1.
- R9: The control field is loaded from `wr_data[4:0]` on a rising `clk_src0` edge with `wr_en` high. `wr_data[7:5]` is ignored.
- R10: When `wr_en` is low, `wr_data` has no effect on the control field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src0 | input | 1 | Master clock 0; also clocks the write port |
| clk_src1 | input | 1 | Master clock 1 |
| clk_src2 | input | 1 | Master clock 2, high-frequency input |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control field write strobe |
| wr_data | input | 8 | Write data; bits [4:0] form the control field |
| pix_clk | output | 1 | Glitch-free selected master clock |
| pix_en | output | 1 | One-cycle pixel enable in the `pix_clk` domain |

## Verification
A corrupted divider count or held ratio appears at the ports within one pixel period: the spacing between `pix_en` pulses no longer matches N source periods. A faulty gate handshake shows up during a source switch. It appears either as a `pix_clk` phase narrower than a source half period, or as a `pix_clk` period that matches none of the expected sources once the switch has settled. A bad control-register load is visible after the two-cycle ratio synchroniser, as a wrong pulse spacing or a wrong clock period.

// File: rtl/pixclk_pkg.sv
package pixclk_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N_SRC  = 3;
  localparam int SEL_W  = 2;
  localparam int DIV_W  = 3;
  localparam int FIELD_W = SEL_W + DIV_W;

  typedef logic [FIELD_W-1:0] ctrl_field_t;

  // Source index from the field; the reserved code folds onto source 0.
  function automatic logic [SEL_W-1:0] src_of(input ctrl_field_t f);
    logic [SEL_W-1:0] code;
    code = f[SEL_W-1:0];
    return (int'(code) >= N_SRC) ? '0 : code;
  endfunction

  // Divide ratio minus one, stored above the source bits.
  function automatic logic [DIV_W-1:0] div_m1_of(input ctrl_field_t f);
    return f[FIELD_W-1:SEL_W];
  endfunction
endpackage

// File: rtl/pixclk_ctrl_reg.sv
module pixclk_ctrl_reg
  import pixclk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SEL_W-1:0]  sel_idx,
  output logic [DIV_W-1:0]  div_m1
);
  timeunit 1ns;
  timeprecision 1ps;

  ctrl_field_t field_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     field_q <= '0;
    else if (wr_en) field_q <= wr_data[FIELD_W-1:0];
  end

  assign sel_idx = src_of(field_q);
  assign div_m1  = div_m1_of(field_q);

  // R10: without a strobe the field keeps its value
  assert_hold_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(field_q));
  // R2: the reserved code never reaches the multiplexer
  assert_sel_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_idx) < N_SRC);
endmodule

// File: rtl/pixclk_glitchless_mux.sv
module pixclk_glitchless_mux
  import pixclk_pkg::*;
(
  input  logic [N_SRC-1:0] clks,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_idx,
  output logic [N_SRC-1:0] en_vec,
  output logic             clk_out
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [N_SRC-1:0] gated;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam logic [N_SRC-1:0] OTHERS = ~(N_SRC'(1) << i);
    logic req;
    logic req_s1;
    logic en_q;

    // Request this source only when every other gate is closed.
    assign req = (int'(sel_idx) == i) && ((en_vec & OTHERS) == '0);

    always_ff @(posedge clks[i] or negedge rst_n) begin
      if (!rst_n) req_s1 <= 1'b0;
      else        req_s1 <= req;
    end

    // Gate enable moves only on the falling edge, while the clock is low.
    always_ff @(negedge clks[i] or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= req_s1;
    end

    assign en_vec[i] = en_q;
    assign gated[i]  = clks[i] & en_q;

    // R6: the gate never toggles while its clock is high
    always @(en_q) begin
      if (rst_n === 1'b1) begin
        assert_gate_low_R6: assert (clks[i] == 1'b0)
          else $error("gate %0d changed with clock high", i);
      end
    end
  end

  assign clk_out = |gated;

  // R7: never more than one gate open
  always_comb begin
    if (rst_n === 1'b1) begin
      assert_onehot_gate_R7: assert ($onehot0(en_vec))
        else $error("several sources gated at once");
    end
  end
endmodule

// File: rtl/pixclk_divider.sv
module pixclk_divider #(
  parameter int DIV_W = 3
) (
  input  logic             pix_clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] ratio_m1_in,
  output logic             pix_en
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [DIV_W-1:0] ratio_s1;
  logic [DIV_W-1:0] ratio_s2;
  logic [DIV_W-1:0] ratio_q;
  logic [DIV_W-1:0] cnt;
  logic             term;

  assign term = (cnt == '0);

  always_ff @(posedge pix_clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_s1 <= '0;
      ratio_s2 <= '0;
    end else begin
      ratio_s1 <= ratio_m1_in;
      ratio_s2 <= ratio_s1;
    end
  end

  always_ff @(posedge pix_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      ratio_q <= '0;
    end else if (term) begin
      ratio_q <= ratio_s2;
      cnt     <= ratio_s2;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign pix_en = term;

  // R3: the count never exceeds the ratio in force
  assert_cnt_bound_R3: assert property (@(posedge pix_clk) disable iff (!rst_n)
    cnt <= ratio_q);
  // R3: a terminal count restarts a full period
  assert_reload_R3: assert property (@(posedge pix_clk) disable iff (!rst_n)
    term |=> (cnt == ratio_q));
  // R5: the ratio in force changes only at a terminal count
  assert_ratio_hold_R5: assert property (@(posedge pix_clk) disable iff (!rst_n)
    !term |=> $stable(ratio_q));
endmodule

// File: rtl/pixclk_sel_div.sv
module pixclk_sel_div
  import pixclk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_src0,
  input  logic              clk_src1,
  input  logic              clk_src2,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pix_clk,
  output logic              pix_en
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [SEL_W-1:0] sel_idx;
  logic [DIV_W-1:0] div_m1;
  logic [N_SRC-1:0] en_vec;
  logic [N_SRC-1:0] clks;

  assign clks = {clk_src2, clk_src1, clk_src0};

  pixclk_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk     (clk_src0),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .sel_idx (sel_idx),
    .div_m1  (div_m1)
  );

  pixclk_glitchless_mux u_mux (
    .clks    (clks),
    .rst_n   (rst_n),
    .sel_idx (sel_idx),
    .en_vec  (en_vec),
    .clk_out (pix_clk)
  );

  pixclk_divider #(.DIV_W(DIV_W)) u_div (
    .pix_clk     (pix_clk),
    .rst_n       (rst_n),
    .ratio_m1_in (div_m1),
    .pix_en      (pix_en)
  );

  // R8: no clock reaches the output during reset
  always_comb begin
    if (rst_n === 1'b0) begin
      assert_quiet_in_reset_R8: assert (pix_clk == 1'b0)
        else $error("pixel clock active in reset");
    end
  end
endmodule

// File: tb/sim_pixclk_sel_div.sv
module sim_pixclk_sel_div;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_PERIOD = 10;
  localparam int P1 = 14;
  localparam int P2 = 6;

  typedef struct {
    string req;
    int    lo;
    int    hi;
  } exp_t;

  logic clk_src0 = 0, clk_src1 = 0, clk_src2 = 0;
  logic rst_n = 0, wr_en = 0;
  logic [7:0] wr_data = 8'h00;
  logic pix_clk, pix_en;

  int checks = 0, errors = 0;
  int min_half = 5;
  exp_t exp_q[$];
  time t_rise = 0, t_fall = 0;

  always #(CLK_PERIOD/2) clk_src0 = ~clk_src0;
  always #(P1/2) clk_src1 = ~clk_src1;
  always #(P2/2) clk_src2 = ~clk_src2;

  pixclk_sel_div u0 (
    .clk_src0 (clk_src0), .clk_src1 (clk_src1), .clk_src2 (clk_src2),
    .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
    .pix_clk (pix_clk), .pix_en (pix_en)
  );

  // expected spacing of pix_en, restated from R1..R4
  function automatic int spacing(input logic [4:0] f);
    int per;
    case (f[1:0])
      2'd1:    per = P1;
      2'd2:    per = P2;
      default: per = CLK_PERIOD;
    endcase
    return (int'(f[4:2]) + 1) * per;
  endfunction

  // R6: phase widths of pix_clk
  always @(posedge pix_clk) begin
    if (rst_n && t_fall != 0) begin
      checks++;
      if (int'($time - t_fall) < min_half) begin
        errors++;
        $display("FAIL R6 low phase actual %0d expected >= %0d", $time - t_fall, min_half);
      end
    end
    t_rise = $time;
  end
  always @(negedge pix_clk) begin
    if (rst_n && t_rise != 0) begin
      checks++;
      if (int'($time - t_rise) < min_half) begin
        errors++;
        $display("FAIL R6 high phase actual %0d expected >= %0d", $time - t_rise, min_half);
      end
    end
    t_fall = $time;
  end

  // monitor: measure pix_en spacing for each queued item
  initial begin
    forever begin
      time t1;
      int gap;
      wait (exp_q.size() > 0);
      do begin @(posedge pix_clk); #1; end while (pix_en !== 1'b1);
      t1 = $time;
      do begin @(posedge pix_clk); #1; end while (pix_en !== 1'b1);
      gap = int'($time - t1);
      checks++;
      if (gap < exp_q[0].lo || gap > exp_q[0].hi) begin
        errors++;
        $display("FAIL %s spacing actual %0d expected %0d..%0d",
                 exp_q[0].req, gap, exp_q[0].lo, exp_q[0].hi);
      end
      void'(exp_q.pop_front());
    end
  end

  task automatic write_ctrl(input logic [7:0] d);
    @(negedge clk_src0);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk_src0);
    wr_en = 1'b0;
  endtask

  task automatic expect_gap(input string r, input int lo, input int hi);
    exp_t e;
    e.req = r; e.lo = lo; e.hi = hi;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
  endtask

  task automatic set_and_check(input string r, input logic [7:0] d, input int mh);
    min_half = mh;
    write_ctrl(d);
    #300;
    expect_gap(r, spacing(d[4:0]), spacing(d[4:0]));
  endtask

  initial begin
    #3;
    repeat (8) begin
      #5;
      checks++;
      if (pix_clk !== 1'b0) begin
        errors++;
        $display("FAIL R8 pix_clk in reset actual %b expected 0", pix_clk);
      end
    end
    rst_n = 1'b1;
    #200;
    expect_gap("R8", CLK_PERIOD, CLK_PERIOD);                // reset: src0, div 1
    set_and_check("R3", 8'd12, 5);                           // src0 div4 -> 40
    set_and_check("R3", 8'd28, 5);                           // src0 div8 -> 80
    set_and_check("R1", 8'd5, 5);                            // src1 div2 -> 28
    set_and_check("R4", 8'd2, 3);                            // src2 div1 -> 6
    set_and_check("R2", 8'd11, 3);                           // code 3 div3 -> 30
    // R5: ratio 3 -> 6 mid-stream, no truncated period
    write_ctrl(8'd23);
    expect_gap("R5", 30, 60);
    #300;
    expect_gap("R5", 60, 60);
    set_and_check("R9", 8'hE1, 5);                           // upper bits ignored -> src1 div1
    // R10: data without strobe leaves the setting alone
    wr_data = 8'h1E;
    repeat (10) @(negedge clk_src0);
    #200;
    expect_gap("R10", P1, P1);
    set_and_check("R10", 8'd17, 7);                          // src1 div5 -> 70
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule